// File: doc/BRIEF.md
# Scrolling word ticker for seven-segment displays

This block drives a row of eight seven-segment digits with the word HELLO and slides it one digit to the left roughly once per second, so the word enters from the right-hand edge and wraps around continuously. The text lives in a ring of character slots, one per digit: five letters and three blanks. Each step of a built-in prescaler rotates the ring by one slot. Every slot is decoded into an active-low segment pattern for its own digit.

All state runs on one fast clock. The step rate comes from a counter that divides that clock, so no derived clock exists. The reset input is asynchronous and active low. Its release is synchronised to the clock inside the block.

Top module: `hello_ticker`

## Requirements
- R1: While reset is applied, the digits from 7 (leftmost) down to 0 (rightmost) show blank, blank, blank, H, E, L, L, O.
- R2: Each step rotates the text one digit to the left. Digit k takes the glyph that digit k-1 showed, and digit 0 takes the glyph that digit 7 showed.
- R3: Digit k drives seg_o[7k+6:7k], with bit 6 as segment g and bit 0 as segment a, all active low. The glyphs are H = 0001001, E = 0000110, L = 1000111, O = 1000000 and blank = 1111111. No other pattern ever appears.
- R4: The internal reset ends on the second rising clock edge after rst_ni goes high. The first rotation happens DIV = CLK_HZ/STEP_HZ edges later, and later rotations follow every DIV edges.
- R5: Between steps the outputs do not change.
- R6: After eight steps the display is the same as the R1 pattern. The sequence therefore has a period of eight steps.
- R7: Pulling rst_ni low at any time restores the R1 pattern without waiting for a clock edge. It also restarts the R4 step timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for all state |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| seg_o | output | 56 | Active-low segments, 7 bits per digit, digit 0 in the low bits |

## Verification
The assertions assume that rst_ni is held low for at least one rising edge, and that nothing is checked before the first reset. They also assume that the step divider is greater than one, so that a step never lasts two cycles in a row. The bench starts with reset applied before the first edge. It always changes rst_ni on falling clock edges, and it builds the design with a divider of six so that many full wrap cycles fit in a short run. It also applies one asynchronous reset in the middle of a step interval and checks the restart against its model.

// File: rtl/hello_ticker_pkg.sv
package hello_ticker_pkg;

  localparam int unsigned SEG_W = 7;
  localparam int unsigned WORD_LEN = 5;

  typedef enum logic [2:0] {
    GLYPH_BLANK = 3'd0,
    GLYPH_H     = 3'd1,
    GLYPH_E     = 3'd2,
    GLYPH_L     = 3'd3,
    GLYPH_O     = 3'd4
  } glyph_e;

  // Slot contents at reset; slot 0 is the rightmost digit.
  function automatic glyph_e start_glyph(input int unsigned slot);
    case (slot)
      0:       start_glyph = GLYPH_O;
      1:       start_glyph = GLYPH_L;
      2:       start_glyph = GLYPH_L;
      3:       start_glyph = GLYPH_E;
      4:       start_glyph = GLYPH_H;
      default: start_glyph = GLYPH_BLANK;
    endcase
  endfunction

  // Active-low segments, bit 6 = g ... bit 0 = a.
  function automatic logic [SEG_W-1:0] glyph_segs(input glyph_e g);
    case (g)
      GLYPH_H: glyph_segs = 7'b0001001;
      GLYPH_E: glyph_segs = 7'b0000110;
      GLYPH_L: glyph_segs = 7'b1000111;
      GLYPH_O: glyph_segs = 7'b1000000;
      default: glyph_segs = 7'b1111111;
    endcase
  endfunction

endpackage

// File: rtl/ticker_rst_sync.sv
module ticker_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_no = stage2_q;

endmodule

// File: rtl/ticker_prescaler.sv
module ticker_prescaler #(
  parameter int unsigned DIV = 50_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic step_o
);

  localparam int unsigned CNT_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             wrap;

  assign wrap = (cnt_q == LAST);

  always_comb begin
    if (wrap) cnt_d = '0;
    else      cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign step_o = wrap;

endmodule

// File: rtl/ticker_ring.sv
module ticker_ring
  import hello_ticker_pkg::*;
#(
  parameter int unsigned NUM_DISP = 8
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   step_i,
  output glyph_e slot_o [NUM_DISP]
);

  glyph_e ring_q [NUM_DISP];
  glyph_e ring_d [NUM_DISP];

  // Left rotation: slot k takes slot k-1, slot 0 takes the top slot.
  always_comb begin
    for (int k = 0; k < NUM_DISP; k++) begin
      ring_d[k] = ring_q[k];
    end
    if (step_i) begin
      ring_d[0] = ring_q[NUM_DISP-1];
      for (int k = 1; k < NUM_DISP; k++) begin
        ring_d[k] = ring_q[k-1];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < NUM_DISP; k++) begin
        ring_q[k] <= start_glyph(k);
      end
    end else begin
      for (int k = 0; k < NUM_DISP; k++) begin
        ring_q[k] <= ring_d[k];
      end
    end
  end

  always_comb begin
    for (int k = 0; k < NUM_DISP; k++) begin
      slot_o[k] = ring_q[k];
    end
  end

endmodule

// File: rtl/ticker_seg_dec.sv
module ticker_seg_dec
  import hello_ticker_pkg::*;
#(
  parameter int unsigned NUM_DISP = 8
) (
  input  glyph_e                    slot_i [NUM_DISP],
  output logic [NUM_DISP*SEG_W-1:0] seg_o
);

  for (genvar k = 0; k < NUM_DISP; k++) begin : g_digit
    assign seg_o[k*SEG_W +: SEG_W] = glyph_segs(slot_i[k]);
  end

endmodule

// File: rtl/hello_ticker.sv
module hello_ticker
  import hello_ticker_pkg::*;
#(
  parameter int unsigned NUM_DISP = 8,
  parameter int unsigned CLK_HZ   = 50_000_000,
  parameter int unsigned STEP_HZ  = 1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  output logic [NUM_DISP*SEG_W-1:0] seg_o
);

  localparam int unsigned DIV = CLK_HZ / STEP_HZ;

  logic   rst_n_sync;
  logic   step;
  glyph_e slots [NUM_DISP];

  ticker_rst_sync u_rst_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n_sync)
  );

  ticker_prescaler #(.DIV(DIV)) u_prescaler (
    .clk_i  (clk_i),
    .rst_ni (rst_n_sync),
    .step_o (step)
  );

  ticker_ring #(.NUM_DISP(NUM_DISP)) u_ring (
    .clk_i  (clk_i),
    .rst_ni (rst_n_sync),
    .step_i (step),
    .slot_o (slots)
  );

  ticker_seg_dec #(.NUM_DISP(NUM_DISP)) u_dec (
    .slot_i (slots),
    .seg_o  (seg_o)
  );

endmodule

// File: rtl/hello_ticker_chk.sv
module hello_ticker_chk
  import hello_ticker_pkg::*;
#(
  parameter int unsigned NUM_DISP = 8,
  parameter int unsigned DIV      = 2
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      rst_n_sync,
  input logic                      step,
  input logic [NUM_DISP*SEG_W-1:0] seg_o
);

  localparam int unsigned W = NUM_DISP * SEG_W;

  function automatic logic [W-1:0] start_segs();
    for (int k = 0; k < NUM_DISP; k++) begin
      start_segs[k*SEG_W +: SEG_W] = glyph_segs(start_glyph(k));
    end
  endfunction

  function automatic logic glyphs_ok(input logic [W-1:0] s);
    int unsigned blanks;
    logic ok;
    blanks = 0;
    ok = 1'b1;
    for (int k = 0; k < NUM_DISP; k++) begin
      case (s[k*SEG_W +: SEG_W])
        7'b1111111: blanks++;
        7'b0001001, 7'b0000110, 7'b1000111, 7'b1000000: ;
        default: ok = 1'b0;
      endcase
    end
    glyphs_ok = ok && (blanks == NUM_DISP - WORD_LEN);
  endfunction

  // R1 / R7: reset seen on an edge gives the start pattern at the next edge
  p_reset_pattern_r1: assert property (@(posedge clk_i)
    !rst_ni |=> (seg_o == start_segs()));

  // R2: a step rotates the digits left by one position
  p_step_rotates_r2: assert property (@(posedge clk_i) disable iff (!rst_n_sync)
    step |=> (seg_o == {$past(seg_o[W-SEG_W-1:0]), $past(seg_o[W-1:W-SEG_W])}));

  // R5: no step, no change
  p_hold_between_r5: assert property (@(posedge clk_i) disable iff (!rst_n_sync)
    !step |=> $stable(seg_o));

  // R3: only legal glyphs, with exactly the word's blanks
  p_glyph_set_r3: assert property (@(posedge clk_i) disable iff (!rst_n_sync)
    glyphs_ok(seg_o));

  // R4: a step lasts a single cycle
  if (DIV > 1) begin : g_pulse
    p_step_single_r4: assert property (@(posedge clk_i) disable iff (!rst_n_sync)
      step |=> !step);
  end

endmodule

bind hello_ticker hello_ticker_chk #(.NUM_DISP(NUM_DISP), .DIV(DIV)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rst_n_sync (rst_n_sync),
  .step       (step),
  .seg_o      (seg_o)
);

// File: tb/hello_ticker_tb_top.sv
module hello_ticker_tb_top;

  localparam int NDISP = 8;
  localparam int DIVB  = 6;
  localparam int W     = NDISP * 7;

  logic         clk_i;
  logic         rst_ni;
  logic [W-1:0] seg_o;

  int checks;
  int fails;
  int edges;
  int rot;
  bit model_on;
  bit done;

  hello_ticker #(.NUM_DISP(NDISP), .CLK_HZ(DIVB), .STEP_HZ(1)) dut_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .seg_o  (seg_o)
  );

  initial clk_i = 1'b0;
  always #2 clk_i = ~clk_i;

  // Glyph table from R3.
  function automatic logic [6:0] seg_of(input byte c);
    case (c)
      "H": seg_of = 7'b0001001;
      "E": seg_of = 7'b0000110;
      "L": seg_of = 7'b1000111;
      "O": seg_of = 7'b1000000;
      default: seg_of = 7'b1111111;
    endcase
  endfunction

  // Text from R1, indexed by digit number (0 = rightmost).
  function automatic byte start_char(input int d);
    string txt;
    txt = "OLLEH   ";
    start_char = txt[d];
  endfunction

  function automatic logic [W-1:0] expect_segs(input int r);
    logic [W-1:0] v;
    for (int d = 0; d < NDISP; d++) begin
      v[d*7 +: 7] = seg_of(start_char(((d - r) % NDISP + NDISP) % NDISP));
    end
    return v;
  endfunction

  // Model: R4 timing, R7 asynchronous restart.
  always @(negedge rst_ni) begin
    edges = 0;
    rot   = 0;
  end

  always @(posedge clk_i) begin
    if (model_on) begin
      if (!rst_ni) begin
        edges = 0;
        rot   = 0;
      end else begin
        edges++;
        if (edges > 2 && ((edges - 2) % DIVB) == 0) rot++;
      end
    end
  end

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: seg_o=%h expected %h (rotations=%0d)", tag, act, exp, rot);
    end
  endtask

  // Compare on every clock, away from the active edge.
  always @(negedge clk_i) begin
    if (model_on && !done) begin
      if (!rst_ni) check("R1 R7", seg_o, expect_segs(0));
      else if (rot > 0 && rot % NDISP == 0) check("R6", seg_o, expect_segs(rot));
      else check("R2 R4 R5", seg_o, expect_segs(rot));
    end
  end

  task automatic finish_run();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      finish_run();
    end
  end

  initial begin
    checks = 0; fails = 0; edges = 0; rot = 0;
    model_on = 1'b0; done = 1'b0;
    rst_ni = 1'b1;
    #1 rst_ni = 1'b0;
    model_on = 1'b1;
    repeat (3) @(negedge clk_i);
    #1;
    // R3: individual glyph fields in the reset state
    check("R3 digit0 O", {49'd0, seg_o[6:0]},   {49'd0, 7'b1000000});
    check("R3 digit1 L", {49'd0, seg_o[13:7]},  {49'd0, 7'b1000111});
    check("R3 digit3 E", {49'd0, seg_o[27:21]}, {49'd0, 7'b0000110});
    check("R3 digit4 H", {49'd0, seg_o[34:28]}, {49'd0, 7'b0001001});
    check("R3 digit7 blank", {49'd0, seg_o[55:49]}, {49'd0, 7'b1111111});
    @(negedge clk_i);
    rst_ni = 1'b1;
    // R2, R4, R5, R6: two full wraps and more
    repeat (DIVB * 19 + 3) @(negedge clk_i);
    // R7: asynchronous reset in the middle of a step interval
    #1 rst_ni = 1'b0;
    #0.5 check("R7 async", seg_o, expect_segs(0));
    @(negedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (DIVB * 10 + 2) @(negedge clk_i);
    #1 finish_run();
  end

endmodule